// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock Unit

This block is the hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register numbers held by the decode stage and by the execute, memory and writeback pipeline registers. From these it picks where each consumer takes its operand from: the register file value carried down the pipe, or a newer result that has not yet been written back.

There are two result sources. One is the ALU result held in the memory-stage register. The other is the writeback-stage register, which holds either an ALU result or data loaded from memory. The consumers are the two ALU operands and the branch zero-detect in the execute stage, and the store-data input of data memory in the memory stage. A value loaded from memory is not ready in time for the instruction right behind the load. When that instruction is in decode and reads the load's target, the unit holds the PC and the fetch/decode register and turns the slot entering execute into a no-op. The older instructions keep moving.

The unit is purely combinational. Its selects apply to the cycle in which the inputs are presented.

Top module: `hfu_top`

## Requirements
- R1: An ALU operand select (`fwd_a_o` for rs, `fwd_b_o` for rt) is 1 (memory-stage ALU result) when the memory stage writes, is not a load, and its destination equals that execute-stage source.
- R2: When only the writeback stage writes a matching destination, the select is 2 if that writeback instruction is not a load (its ALU result) and 3 if it is a load (its memory data).
- R3: When the memory stage and the writeback stage both match the same source, the memory stage wins and the select is 1.
- R4: Register 0 never forwards and never interlocks. A stage whose write enable is low never matches. With no match the select is 0 (register file value).
- R5: A load in the memory stage never supplies select 1. A matching source falls through to the writeback-stage check, and then to 0.
- R6: `fwd_zero_o` equals the rs operand select while the execute-stage instruction is a branch, and is 0 otherwise.
- R7: `fwd_store_o` is 2 (writeback ALU result) or 3 (writeback load data) when the memory-stage instruction is a store whose data register equals a writing, nonzero writeback destination. Otherwise it is 0.
- R8: `hold_o` is 1 when the execute stage holds a writing load with a nonzero destination, and the decode instruction reads that register through an rs or rt operand it actually uses. Unused operands, non-loads and register 0 give 0.
- R9: `bubble_o` always equals `hold_o`. During a stall the PC and the fetch/decode register hold, and the execute-stage register takes a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | 5 | Decode-stage rs number |
| id_rt_i | input | 5 | Decode-stage rt number |
| id_rs_used_i | input | 1 | Decode instruction reads rs |
| id_rt_used_i | input | 1 | Decode instruction reads rt |
| ex_rs_i | input | 5 | Execute-stage rs number |
| ex_rt_i | input | 5 | Execute-stage rt number |
| ex_rd_i | input | 5 | Execute-stage destination |
| ex_we_i | input | 1 | Execute-stage register write enable |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| ex_branch_i | input | 1 | Execute-stage instruction is a branch |
| mem_rd_i | input | 5 | Memory-stage destination |
| mem_we_i | input | 1 | Memory-stage register write enable |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| mem_st_src_i | input | 5 | Memory-stage store data register |
| wb_rd_i | input | 5 | Writeback-stage destination |
| wb_we_i | input | 1 | Writeback-stage register write enable |
| wb_load_i | input | 1 | Writeback-stage instruction is a load |
| fwd_a_o | output | 2 | ALU operand A select (0 regfile, 1 mem ALU, 2 wb ALU, 3 wb load) |
| fwd_b_o | output | 2 | ALU operand B select, same coding |
| fwd_zero_o | output | 2 | Branch zero-detect select, same coding |
| fwd_store_o | output | 2 | Store-data select, same coding |
| hold_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Clear write and memory enables entering execute |

## Verification
The unit holds no state, so a wrong comparison shows on the select or stall outputs in the same cycle as the inputs that trigger it. A wrong priority, a missing register-0 guard or a wrong load exclusion therefore shows up as a wrong select code for one specific set of stage inputs. The bench drives each pattern in isolation and then in combination: same-source double matches, loads at each stage, stores fed by writeback loads, and interlocks through each decode operand. That way each such fault changes at least one observed code.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE    = 2'd0,
    SEL_EXMEM_ALU  = 2'd1,
    SEL_MEMWB_ALU  = 2'd2,
    SEL_MEMWB_LOAD = 2'd3
  } fwd_sel_e;

endpackage

// File: rtl/hfu_operand_sel.sv
module hfu_operand_sel
  import hfu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] near_rd_i,
  input  logic          near_we_i,
  input  logic          near_load_i,
  input  logic [AW-1:0] far_rd_i,
  input  logic          far_we_i,
  input  logic          far_load_i,
  output fwd_sel_e      sel_o
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic near_hit;
  logic far_hit;

  always_comb begin
    near_hit = near_we_i && !near_load_i && (near_rd_i != ZERO_REG) && (near_rd_i == src_i);
    far_hit  = far_we_i && (far_rd_i != ZERO_REG) && (far_rd_i == src_i);
  end

  always_comb begin
    if (near_hit) begin
      sel_o = SEL_EXMEM_ALU;
    end else if (far_hit) begin
      sel_o = far_load_i ? SEL_MEMWB_LOAD : SEL_MEMWB_ALU;
    end else begin
      sel_o = SEL_REGFILE;
    end
  end

  always_comb begin
    if (sel_o == SEL_EXMEM_ALU) begin
      AST_NEAR_NOT_LOAD: assert (!near_load_i && near_we_i) else $error("near forward from load"); // R5
    end
    if (sel_o != SEL_REGFILE) begin
      AST_NONZERO_SRC: assert (src_i != ZERO_REG) else $error("forward of register 0"); // R4
    end
    if (sel_o == SEL_MEMWB_LOAD) begin
      AST_FAR_LOAD_KIND: assert (far_load_i && far_we_i) else $error("load select without load"); // R2
    end
  end

endmodule

// File: rtl/hfu_store_sel.sv
module hfu_store_sel
  import hfu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          store_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] far_rd_i,
  input  logic          far_we_i,
  input  logic          far_load_i,
  output fwd_sel_e      sel_o
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic far_hit;

  always_comb begin
    far_hit = store_i && far_we_i && (far_rd_i != ZERO_REG) && (far_rd_i == src_i);
  end

  always_comb begin
    if (far_hit) begin
      sel_o = far_load_i ? SEL_MEMWB_LOAD : SEL_MEMWB_ALU;
    end else begin
      sel_o = SEL_REGFILE;
    end
  end

  always_comb begin
    if (sel_o != SEL_REGFILE) begin
      AST_STORE_SRC_NONZERO: assert (store_i && (src_i != ZERO_REG)) else $error("bad store forward"); // R7
    end
    if (sel_o == SEL_EXMEM_ALU) begin
      AST_STORE_NO_NEAR: assert (1'b0) else $error("store select from memory stage"); // R7
    end
  end

endmodule

// File: rtl/hfu_load_use.sv
module hfu_load_use #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0] id_src_i,
  input  logic [NUM_SRC-1:0]         id_used_i,
  input  logic [AW-1:0]              ex_rd_i,
  input  logic                       ex_we_i,
  input  logic                       ex_load_i,
  output logic                       stall_o
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] src_hit;
  logic               load_live;

  always_comb begin
    load_live = ex_load_i && ex_we_i && (ex_rd_i != ZERO_REG);
    for (int i = 0; i < NUM_SRC; i++) begin
      src_hit[i] = id_used_i[i] && (id_src_i[i] == ex_rd_i);
    end
    stall_o = load_live && (|src_hit);
  end

  always_comb begin
    if (stall_o) begin
      AST_STALL_ON_LOAD: assert (ex_load_i && (ex_rd_i != ZERO_REG)) else $error("stall without load"); // R8
      AST_STALL_USED_SRC: assert (|id_used_i) else $error("stall with no used operand"); // R8
    end
  end

endmodule

// File: rtl/hfu_top.sv
module hfu_top
  import hfu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_rs_used_i,
  input  logic          id_rt_used_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic          ex_branch_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic          mem_store_i,
  input  logic [AW-1:0] mem_st_src_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic          wb_load_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic [1:0]    fwd_zero_o,
  output logic [1:0]    fwd_store_o,
  output logic          hold_o,
  output logic          bubble_o
);

  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][AW-1:0] ex_src;
  logic [NUM_OPS-1:0][AW-1:0] id_src;
  logic [NUM_OPS-1:0]         id_used;
  fwd_sel_e                   op_sel [NUM_OPS];
  fwd_sel_e                   st_sel;
  fwd_sel_e                   zero_sel;
  logic                       stall;

  always_comb begin
    ex_src[0]  = ex_rs_i;
    ex_src[1]  = ex_rt_i;
    id_src[0]  = id_rs_i;
    id_src[1]  = id_rt_i;
    id_used[0] = id_rs_used_i;
    id_used[1] = id_rt_used_i;
  end

  generate
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
      hfu_operand_sel #(.AW(AW)) i_sel (
        .src_i       (ex_src[g]),
        .near_rd_i   (mem_rd_i),
        .near_we_i   (mem_we_i),
        .near_load_i (mem_load_i),
        .far_rd_i    (wb_rd_i),
        .far_we_i    (wb_we_i),
        .far_load_i  (wb_load_i),
        .sel_o       (op_sel[g])
      );
    end
  endgenerate

  hfu_store_sel #(.AW(AW)) i_store (
    .store_i    (mem_store_i),
    .src_i      (mem_st_src_i),
    .far_rd_i   (wb_rd_i),
    .far_we_i   (wb_we_i),
    .far_load_i (wb_load_i),
    .sel_o      (st_sel)
  );

  hfu_load_use #(.AW(AW), .NUM_SRC(NUM_OPS)) i_load_use (
    .id_src_i  (id_src),
    .id_used_i (id_used),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .stall_o   (stall)
  );

  always_comb begin
    zero_sel    = ex_branch_i ? op_sel[0] : SEL_REGFILE;
    fwd_a_o     = op_sel[0];
    fwd_b_o     = op_sel[1];
    fwd_zero_o  = zero_sel;
    fwd_store_o = st_sel;
    hold_o      = stall;
    bubble_o    = stall;
  end

  always_comb begin
    AST_HOLD_BUBBLE_PAIR: assert (hold_o == bubble_o) else $error("hold and bubble differ"); // R9
    if (!ex_branch_i) begin
      AST_ZERO_IDLE: assert (fwd_zero_o == 2'd0) else $error("zero select without branch"); // R6
    end
    if (!mem_store_i) begin
      AST_STORE_IDLE: assert (fwd_store_o == 2'd0) else $error("store select without store"); // R7
    end
    if (mem_we_i && !mem_load_i && (mem_rd_i != '0) && (mem_rd_i == ex_rs_i)) begin
      AST_NEAR_PRIORITY: assert (fwd_a_o == 2'd1) else $error("memory stage lost priority"); // R3
    end
  end

endmodule

// File: tb/test_hfu_top.sv
module test_hfu_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_st_src, wb_rd;
  logic       id_rs_used, id_rt_used, ex_we, ex_load, ex_branch;
  logic       mem_we, mem_load, mem_store, wb_we, wb_load;
  logic [1:0] fwd_a, fwd_b, fwd_zero, fwd_store;
  logic       hold, bubble;

  int n_checks = 0;
  int n_fail   = 0;

  hfu_top i_hfu_top (
    .id_rs_i      (id_rs),
    .id_rt_i      (id_rt),
    .id_rs_used_i (id_rs_used),
    .id_rt_used_i (id_rt_used),
    .ex_rs_i      (ex_rs),
    .ex_rt_i      (ex_rt),
    .ex_rd_i      (ex_rd),
    .ex_we_i      (ex_we),
    .ex_load_i    (ex_load),
    .ex_branch_i  (ex_branch),
    .mem_rd_i     (mem_rd),
    .mem_we_i     (mem_we),
    .mem_load_i   (mem_load),
    .mem_store_i  (mem_store),
    .mem_st_src_i (mem_st_src),
    .wb_rd_i      (wb_rd),
    .wb_we_i      (wb_we),
    .wb_load_i    (wb_load),
    .fwd_a_o      (fwd_a),
    .fwd_b_o      (fwd_b),
    .fwd_zero_o   (fwd_zero),
    .fwd_store_o  (fwd_store),
    .hold_o       (hold),
    .bubble_o     (bubble)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs = 0; id_rt = 0; id_rs_used = 0; id_rt_used = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_we = 0; ex_load = 0; ex_branch = 0;
    mem_rd = 0; mem_we = 0; mem_load = 0; mem_store = 0; mem_st_src = 0;
    wb_rd = 0; wb_we = 0; wb_load = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    idle(); settle();
    check("R4 idle a", fwd_a, 0);
    check("R4 idle b", fwd_b, 0);
    check("R6 idle zero", fwd_zero, 0);
    check("R7 idle store", fwd_store, 0);
    check("R8 idle hold", hold, 0);
    check("R9 idle bubble", bubble, 0);
  endtask

  task automatic t_mem_forward();
    idle(); ex_rs = 3; ex_rt = 8; mem_rd = 3; mem_we = 1; settle();
    check("R1 a from mem", fwd_a, 1);
    check("R1 b untouched", fwd_b, 0);
    ex_rt = 3; settle();
    check("R1 b from mem", fwd_b, 1);
  endtask

  task automatic t_wb_forward();
    idle(); ex_rs = 7; ex_rt = 7; wb_rd = 7; wb_we = 1; settle();
    check("R2 a wb alu", fwd_a, 2);
    wb_load = 1; settle();
    check("R2 b wb load", fwd_b, 3);
    check("R2 a wb load", fwd_a, 3);
  endtask

  task automatic t_priority();
    idle(); ex_rs = 4; ex_rt = 4; mem_rd = 4; mem_we = 1; wb_rd = 4; wb_we = 1; wb_load = 1; settle();
    check("R3 a mem wins", fwd_a, 1);
    check("R3 b mem wins", fwd_b, 1);
  endtask

  task automatic t_zero_reg();
    idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1; settle();
    check("R4 reg0 a", fwd_a, 0);
    idle(); ex_rs = 9; mem_rd = 9; mem_we = 0; wb_rd = 9; wb_we = 0; settle();
    check("R4 we low", fwd_a, 0);
    mem_we = 1; wb_we = 1; settle();
    check("R4 we back", fwd_a, 1);
  endtask

  task automatic t_mem_load();
    idle(); ex_rs = 5; mem_rd = 5; mem_we = 1; mem_load = 1; settle();
    check("R5 mem load no fwd", fwd_a, 0);
    wb_rd = 5; wb_we = 1; settle();
    check("R5 falls to wb", fwd_a, 2);
  endtask

  task automatic t_zero_detect();
    idle(); ex_rs = 6; mem_rd = 6; mem_we = 1; settle();
    check("R6 no branch", fwd_zero, 0);
    ex_branch = 1; settle();
    check("R6 branch mem", fwd_zero, 1);
    mem_we = 0; wb_rd = 6; wb_we = 1; wb_load = 1; settle();
    check("R6 branch wb load", fwd_zero, 3);
  endtask

  task automatic t_store();
    idle(); mem_st_src = 9; wb_rd = 9; wb_we = 1; wb_load = 1; settle();
    check("R7 not store", fwd_store, 0);
    mem_store = 1; settle();
    check("R7 store load data", fwd_store, 3);
    wb_load = 0; settle();
    check("R7 store alu", fwd_store, 2);
    mem_st_src = 0; wb_rd = 0; settle();
    check("R7 store reg0", fwd_store, 0);
    mem_st_src = 9; wb_rd = 9; mem_rd = 9; mem_we = 1; wb_we = 0; settle();
    check("R7 mem stage ignored", fwd_store, 0);
  endtask

  task automatic t_load_use();
    idle(); ex_load = 1; ex_we = 1; ex_rd = 12; id_rs = 12; id_rs_used = 1; settle();
    check("R8 rs stall", hold, 1);
    check("R9 bubble with stall", bubble, 1);
    id_rs_used = 0; settle();
    check("R8 rs unused", hold, 0);
    id_rt = 12; id_rt_used = 1; settle();
    check("R8 rt stall", hold, 1);
    ex_load = 0; settle();
    check("R8 not load", hold, 0);
    check("R9 no bubble", bubble, 0);
    ex_load = 1; ex_rd = 0; id_rt = 0; settle();
    check("R8 reg0 no stall", hold, 0);
    ex_rd = 12; id_rt = 12; ex_we = 0; settle();
    check("R8 we low", hold, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_mem_forward();
    t_wb_forward();
    t_priority();
    t_zero_reg();
    t_mem_load();
    t_zero_detect();
    t_store();
    t_load_use();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule